// File: doc/BRIEF.md
# Clock-Count Configuration Register

This block holds the configuration of a serial-output converter and is programmed only through the serial clock. After a conversion ends, the host starts a readout and stops it early. The number of SCK rising edges it gave while the device was selected is the command. The command is applied when the device is deselected. A complete readout of 14 or more edges leaves the configuration unchanged. This lets a host that never cuts a readout short read results without changing any setting.

The register holds a one-hot operating mode (fast, normal, low-power), an input-bandwidth bit, a busy-synchronisation bit and an SCK driving-edge bit. It also holds a flag that asks for the configuration to be read back. Selection is decoded in one of three ways. In chain mode the device is selected while CNV is high. In chip-select 3-wire use it is selected while CNV is low and SDI is high. In chip-select 4-wire use it is selected while SDI is low and CNV is high. All three inputs arrive already synchronised to the block clock, together with a chain-mode flag and a conversion-done pulse.

The block gives the serial port a 14-bit readback word and a flag that says the word replaces one readout. The conversion sequencer gets a one-cycle pulse whenever the operating mode changes.

Top module: `sck_count_config`

## Requirements
- R1: After reset and after a commit of count 3 or count 8, the configuration is: fast mode (cfgMode = 3'b001), bwHigh = 1, busySync = 0, edgeRise = 0. After reset, rbValid = 0 and modePulse = 0.
- R2: A committed count of 4 inverts bwHigh. A count of 5 inverts busySync. A count of 6 inverts edgeRise.
- R3: cfgMode is one-hot with low-power on bit 2, normal on bit 1 and fast on bit 0. A committed count of 9 selects low-power, 11 selects normal and 13 selects fast.
- R4: Committed counts of 0, 1, 2, 10, 12 and any count of 14 or more leave the whole configuration unchanged. The edge counter saturates at 15, so a long burst of edges also has no effect.
- R5: In chain mode (chainMode = 1), SCK rising edges are counted while CNV is high after a conversion-done pulse. The count is applied on the falling edge of CNV. Only one command takes effect per conversion.
- R6: In chip-select mode, SCK rising edges are counted while CNV is low and SDI is high after conversion end. The count is applied when CNV rises. Only one command takes effect per conversion.
- R7: In chip-select mode, SCK rising edges are counted while SDI is low and CNV is high. The count is applied on every SDI rising edge. The count keeps accumulating since conversion end, so several commands can take effect within one conversion.
- R8: In chip-select mode, once CNV and SDI have been low together after a conversion end, SCK edges are ignored and every deselect until the next conversion end leaves the configuration unchanged.
- R9: A committed count of 7 sets rbValid = 1. rbWord is 14 bits, MSB first: 1, 1, 0, bwHigh, busySync, edgeRise, 0, 0, low-power, 0, normal, 0, fast, 0 (the defaults give 14'h3402). The next commit clears rbValid, so the word covers exactly one readout.
- R10: modePulse is high for one cycle, in the same cycle the new mode first appears on cfgMode, exactly when the operating mode changes value.
- R11: Each conversion-done pulse clears the edge counter. No edge is counted before the first conversion-done pulse after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cnvIn | input | 1 | Synchronised convert/select line |
| sdiIn | input | 1 | Synchronised serial data input line |
| sckIn | input | 1 | Synchronised serial clock level |
| chainMode | input | 1 | 1 = chain mode, 0 = chip-select mode |
| convDone | input | 1 | One-cycle pulse at conversion end |
| cfgMode | output | 3 | One-hot mode: bit 2 low-power, bit 1 normal, bit 0 fast |
| cfgBwHigh | output | 1 | 1 = high input bandwidth |
| cfgBusySync | output | 1 | 1 = synchronous busy indication |
| cfgEdgeRise | output | 1 | 1 = SCK rising edge drives data out |
| rbValid | output | 1 | Readback word replaces the next readout |
| rbWord | output | 14 | Configuration readback word, MSB first |
| modePulse | output | 1 | One-cycle pulse on a mode change |

## Verification
The assertions check on every cycle the following properties:
- The configuration changes only in the cycle after a commit strobe.
- A count of 14 or more never alters it.
- The mode stays one-hot.
- The counter falls only after a conversion-done pulse, and rises only on an SCK rising edge.
- modePulse lines up exactly with changes of the mode value.

Only the bench's scenarios can show the following:
- The command decode against its count table.
- The three selection windows and their commit edges.
- The one-command-per-conversion limit in chain and 3-wire use, against several accumulated commands in 4-wire use.
- Blocking after CNV and SDI are low together.
- The one-readout lifetime of the readback word.

// File: rtl/sck_count_config_pkg.sv
package sck_count_config_pkg;

  localparam int CNT_W = 4;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int WORD_W = 14;

  localparam int MODE_LP = 2;
  localparam int MODE_NORMAL = 1;
  localparam int MODE_FAST = 0;

  typedef struct packed {
    logic [2:0] mode;
    logic bwHigh;
    logic busySync;
    logic edgeRise;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{mode: 3'b001, bwHigh: 1'b1, busySync: 1'b0, edgeRise: 1'b0};

  typedef enum logic [2:0] {
    CMD_NONE, CMD_DEFAULTS, CMD_TOG_BW, CMD_TOG_BUSY,
    CMD_TOG_EDGE, CMD_READBACK, CMD_SET_MODE
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commitEn;
    logic [CNT_W-1:0] count;
  } strobe_t;

  function automatic cmd_e decodeCount(input logic [CNT_W-1:0] n);
    case (n)
      3, 8: decodeCount = CMD_DEFAULTS;
      4: decodeCount = CMD_TOG_BW;
      5: decodeCount = CMD_TOG_BUSY;
      6: decodeCount = CMD_TOG_EDGE;
      7: decodeCount = CMD_READBACK;
      9, 11, 13: decodeCount = CMD_SET_MODE;
      default: decodeCount = CMD_NONE;
    endcase
  endfunction

  function automatic logic [2:0] modeFromCount(input logic [CNT_W-1:0] n);
    logic [2:0] m;
    m = '0;
    if (n == 9) m[MODE_LP] = 1'b1;
    else if (n == 11) m[MODE_NORMAL] = 1'b1;
    else m[MODE_FAST] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sck_count_ctrl.sv
module sck_count_ctrl
  import sck_count_config_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cnvIn,
  input  logic sdiIn,
  input  logic sckIn,
  input  logic chainMode,
  input  logic convDone,
  output strobe_t stb
);

  logic cnvPrev, sdiPrev, sckPrev;
  logic armedOnce, armedAny, seen3, blocked;
  logic [CNT_W-1:0] cnt;

  logic sckRise, cnvRise, cnvFall, sdiRise;
  logic bothLow, win3, win4, winC, countWin;
  logic commitC, commit3, commit4;

  always_comb begin
    sckRise = sckIn & ~sckPrev;
    cnvRise = cnvIn & ~cnvPrev;
    cnvFall = ~cnvIn & cnvPrev;
    sdiRise = sdiIn & ~sdiPrev;
    bothLow = ~chainMode & ~cnvIn & ~sdiIn;
    winC = chainMode & cnvIn & armedOnce;
    win3 = ~chainMode & ~cnvIn & sdiIn & armedOnce & ~blocked;
    win4 = ~chainMode & cnvIn & ~sdiIn & armedAny & ~blocked;
    countWin = winC | win3 | win4;
    commitC = chainMode & cnvFall & armedOnce;
    commit3 = ~chainMode & cnvRise & armedOnce & seen3 & ~blocked;
    commit4 = ~chainMode & cnvIn & cnvPrev & sdiRise & armedAny & ~blocked;
    stb.commitEn = (commitC | commit3 | commit4) & ~convDone;
    stb.count = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnvPrev <= 1'b0;
      sdiPrev <= 1'b0;
      sckPrev <= 1'b0;
    end else begin
      cnvPrev <= cnvIn;
      sdiPrev <= sdiIn;
      sckPrev <= sckIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      armedOnce <= 1'b0;
      armedAny <= 1'b0;
      seen3 <= 1'b0;
      blocked <= 1'b0;
    end else if (convDone) begin
      cnt <= '0;
      armedOnce <= 1'b1;
      armedAny <= 1'b1;
      seen3 <= 1'b0;
      blocked <= 1'b0;
    end else begin
      if (countWin && sckRise && cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      if (win3) seen3 <= 1'b1;
      if (bothLow && armedAny) blocked <= 1'b1;
      if (stb.commitEn) armedOnce <= 1'b0;
    end
  end

  // R11: counter returns to zero after each conversion end
  assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> (cnt == '0));

  // R4 / R11: counter only falls after a conversion end
  assert_cnt_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cnt < $past(cnt)) |-> $past(convDone));

  // R11: counter only rises on an SCK rising edge
  assert_cnt_on_edge_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cnt > $past(cnt)) |-> ($past(sckIn) && !$past(sckPrev)));

  // R8: no commit once a joint low has been seen
  assert_blocked_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (blocked && !chainMode) |-> !stb.commitEn);

endmodule

// File: rtl/sck_count_regs.sv
module sck_count_regs
  import sck_count_config_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t stb,
  output cfg_t cfgQ,
  output logic rbValid,
  output logic [WORD_W-1:0] rbWord,
  output logic modePulse
);

  cfg_t cfgNext;
  cmd_e cmd;

  always_comb begin
    cmd = decodeCount(stb.count);
    cfgNext = cfgQ;
    if (stb.commitEn) begin
      case (cmd)
        CMD_DEFAULTS: cfgNext = CFG_DEFAULT;
        CMD_TOG_BW: cfgNext.bwHigh = ~cfgQ.bwHigh;
        CMD_TOG_BUSY: cfgNext.busySync = ~cfgQ.busySync;
        CMD_TOG_EDGE: cfgNext.edgeRise = ~cfgQ.edgeRise;
        CMD_SET_MODE: cfgNext.mode = modeFromCount(stb.count);
        default: cfgNext = cfgQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= CFG_DEFAULT;
      rbValid <= 1'b0;
      modePulse <= 1'b0;
    end else begin
      cfgQ <= cfgNext;
      modePulse <= (cfgNext.mode != cfgQ.mode);
      if (stb.commitEn) rbValid <= (cmd == CMD_READBACK);
    end
  end

  always_comb begin
    rbWord = {2'b11, 1'b0, cfgQ.bwHigh, cfgQ.busySync, cfgQ.edgeRise, 2'b00,
              cfgQ.mode[MODE_LP], 1'b0, cfgQ.mode[MODE_NORMAL], 1'b0,
              cfgQ.mode[MODE_FAST], 1'b0};
  end

  // R5/R6/R7: configuration moves only after a commit strobe
  assert_change_needs_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ != $past(cfgQ)) |-> $past(stb.commitEn));

  // R4: a full readout never alters the configuration
  assert_full_read_noop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitEn && stb.count >= 14) |=> $stable(cfgQ));

  // R3: mode stays one-hot
  assert_mode_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cfgQ.mode) == 1);

  // R10: pulse aligns exactly with a mode change
  assert_pulse_on_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.mode != $past(cfgQ.mode)) |-> modePulse);
  assert_pulse_only_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    modePulse |-> (cfgQ.mode != $past(cfgQ.mode)));

endmodule

// File: rtl/sck_count_config.sv
module sck_count_config
  import sck_count_config_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cnvIn,
  input  logic sdiIn,
  input  logic sckIn,
  input  logic chainMode,
  input  logic convDone,
  output logic [2:0] cfgMode,
  output logic cfgBwHigh,
  output logic cfgBusySync,
  output logic cfgEdgeRise,
  output logic rbValid,
  output logic [13:0] rbWord,
  output logic modePulse
);

  strobe_t stb;
  cfg_t cfgQ;

  sck_count_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sdiIn(sdiIn), .sckIn(sckIn),
    .chainMode(chainMode), .convDone(convDone), .stb(stb)
  );

  sck_count_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgQ(cfgQ),
    .rbValid(rbValid), .rbWord(rbWord), .modePulse(modePulse)
  );

  assign cfgMode = cfgQ.mode;
  assign cfgBwHigh = cfgQ.bwHigh;
  assign cfgBusySync = cfgQ.busySync;
  assign cfgEdgeRise = cfgQ.edgeRise;

endmodule

// File: tb/tb_sck_count_config.sv
module tb_sck_count_config;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvIn = 1'b0, sdiIn = 1'b0, sckIn = 1'b0, chainMode = 1'b1, convDone = 1'b0;
  logic [2:0] cfgMode;
  logic cfgBwHigh, cfgBusySync, cfgEdgeRise, rbValid, modePulse;
  logic [13:0] rbWord;

  int testsRun = 0;
  int testsFailed = 0;
  int pulseCount = 0;

  always #10 clk = ~clk;

  sck_count_config dut (
    .clk(clk), .rstN(rstN), .cnvIn(cnvIn), .sdiIn(sdiIn), .sckIn(sckIn),
    .chainMode(chainMode), .convDone(convDone), .cfgMode(cfgMode),
    .cfgBwHigh(cfgBwHigh), .cfgBusySync(cfgBusySync), .cfgEdgeRise(cfgEdgeRise),
    .rbValid(rbValid), .rbWord(rbWord), .modePulse(modePulse)
  );

  always @(posedge clk) if (rstN && modePulse) pulseCount++;

  // {count[4:0], mode[2:0], bw, busy, edge}
  localparam logic [10:0] VEC [0:14] = '{
    {5'd4,  6'b001_000}, {5'd5,  6'b001_010}, {5'd6,  6'b001_011},
    {5'd9,  6'b100_011}, {5'd2,  6'b100_011}, {5'd11, 6'b010_011},
    {5'd14, 6'b010_011}, {5'd10, 6'b010_011}, {5'd20, 6'b010_011},
    {5'd3,  6'b001_100}, {5'd5,  6'b001_110}, {5'd8,  6'b001_100},
    {5'd13, 6'b001_100}, {5'd12, 6'b001_100}, {5'd0,  6'b001_100}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] cfgNow();
    return {cfgMode, cfgBwHigh, cfgBusySync, cfgEdgeRise};
  endfunction

  function automatic logic [13:0] wordOf(input logic [5:0] c);
    return {3'b110, c[2], c[1], c[0], 2'b00, c[5], 1'b0, c[4], 1'b0, c[3], 1'b0};
  endfunction

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sckIn = 1'b1; tick();
      sckIn = 1'b0; tick();
    end
  endtask

  task automatic doneBlip();
    convDone = 1'b1; tick();
    convDone = 1'b0; tick();
  endtask

  task automatic chainCmd(input int n);
    chainMode = 1'b1; cnvIn = 1'b1; tick();
    doneBlip();
    pulses(n);
    cnvIn = 1'b0; tick(); tick();
  endtask

  initial begin
    #(20 * 200000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [5:0] expCfg;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 cfg after reset", cfgNow(), 6'b001_100);
    check("R1 rbValid after reset", rbValid, 0);
    check("R1 modePulse after reset", modePulse, 0);
    check("R9 default word", rbWord, 14'h3402);

    // table: R2 R3 R4 R1 in chain mode
    for (int i = 0; i < 15; i++) begin
      chainCmd(int'(VEC[i][10:6]));
      check($sformatf("R2/R3/R4/R1 vector %0d count %0d", i, VEC[i][10:6]), cfgNow(), VEC[i][5:0]);
    end
    check("R10 pulses over table", pulseCount, 3);

    // R9 readback for one readout
    chainCmd(7);
    check("R9 rbValid set", rbValid, 1);
    check("R9 word", rbWord, wordOf(6'b001_100));
    chainCmd(14);
    check("R9 rbValid cleared after readout", rbValid, 0);
    check("R4 full readout no change", cfgNow(), 6'b001_100);

    // R5 one change per conversion in chain mode
    cnvIn = 1'b1; tick(); doneBlip();
    pulses(4); cnvIn = 1'b0; tick(); tick();
    cnvIn = 1'b1; tick(); pulses(4); cnvIn = 1'b0; tick(); tick();
    check("R5 single change per conversion", cfgNow(), 6'b001_000);

    // R11 conversion end clears count
    cnvIn = 1'b1; tick(); doneBlip();
    pulses(3); doneBlip(); pulses(4);
    cnvIn = 1'b0; tick(); tick();
    check("R11 count cleared by conversion end", cfgNow(), 6'b001_100);
    check("R11 no readback from stale count", rbValid, 0);

    // R6 3-wire chip-select
    chainMode = 1'b0; cnvIn = 1'b1; sdiIn = 1'b1; tick();
    doneBlip();
    cnvIn = 1'b0; tick(); pulses(6);
    cnvIn = 1'b1; tick(); tick();
    check("R6 edge toggle via 3-wire", cfgNow(), 6'b001_101);

    // R7 4-wire accumulating commands
    doneBlip();
    sdiIn = 1'b0; tick(); pulses(5); sdiIn = 1'b1; tick(); tick();
    check("R7 first 4-wire command", cfgNow(), 6'b001_111);
    sdiIn = 1'b0; tick(); pulses(4); sdiIn = 1'b1; tick(); tick();
    check("R7 accumulated count selects low-power", cfgNow(), 6'b100_111);
    check("R10 pulse count after 4-wire mode change", pulseCount, 4);

    // R8 both low ignored
    doneBlip();
    cnvIn = 1'b0; sdiIn = 1'b0; tick(); pulses(4);
    sdiIn = 1'b1; tick(); cnvIn = 1'b1; tick(); tick();
    expCfg = 6'b100_111;
    check("R8 joint low leaves config", cfgNow(), expCfg);
    check("R10 no spurious pulse", pulseCount, 4);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule